// File: doc/BRIEF.md
# SPI Serial Clock Baud Divider

This block takes the system clock and derives the timing for the SPI serial clock. It emits a one-cycle half-period strobe for the shift engine and keeps a serial-clock level that flips on every strobe. The half period is set by two configuration inputs. The first is a 4-bit prescale modulus `pm`. The second is a divide-by-16 select `div16`. The total clock division is 4×(pm+1), and it is multiplied by 16 when `div16` is set. This gives a total range from 4 to 1024.

The configuration is captured only while `enable` is low, so changing the inputs in the middle of a word cannot disturb the clock. After reset the captured configuration is the slowest setting: pm = 0xF with divide-by-16 set. Driving `start` high while enabled restarts the timing, so the first strobe comes one full half period later. Choosing `pm` and `div16` from a target frequency is left to software. Clock polarity and phase belong to the shift engine.

The control is a three-state machine:
- **ST_OFF** is the disabled state. It moves to ST_RUN when `enable` is sampled high.
- **ST_RUN** is the counting state.
  - It moves to ST_EDGE when the count reaches the last cycle of the half period and `start` is low.
  - It stays in ST_RUN on `start` or when the count is not terminal.
- **ST_EDGE** lasts one cycle and drives the strobe.
  - It returns to ST_RUN.
  - It moves to ST_EDGE again only on a terminal count.
- Both ST_RUN and ST_EDGE fall back to ST_OFF whenever `enable` is sampled low.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, `half_tick` and `sck` are 0. The captured configuration is pm = 15 with divide-by-16 set. If `enable` is high from reset onward, the first strobe appears after the 512th rising edge.
- R2: With divide-by-16 clear, strobes repeat every 2×(pm+1) cycles, where pm is the 4-bit unsigned value. This gives a full serial-clock period of 4×(pm+1).
- R3: With divide-by-16 set, strobes repeat every 32×(pm+1) cycles. This gives a full period of 64×(pm+1), with a maximum of 1024.
- R4: `half_tick` is high for exactly one cycle per half period. `sck` inverts in the same cycle that `half_tick` is high and at no other time while enabled and not restarting.
- R5: While `enable` is sampled low, `half_tick` and `sck` are 0 from the next cycle on, and the counters are cleared.
- R6: When `start` is sampled high with `enable` high, `sck` is 0 and `half_tick` is 0 in the next cycle. The next strobe follows exactly one half period after that start edge.
- R7: `pm` and `div16` are captured on every edge where `enable` is low. Changes made while enabled do not alter the strobe spacing.
- R8: On enabling, the first strobe appears after the N-th rising edge at which `enable` is sampled high, where N is the half period. The enabling edge counts as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears timing and captures configuration |
| start | input | 1 | Transfer start; restarts the half-period timing |
| pm | input | 4 | Prescale modulus |
| div16 | input | 1 | Selects the extra divide-by-16 |
| half_tick | output | 1 | One-cycle strobe at twice the serial-clock rate |
| sck | output | 1 | Serial-clock level, toggles on each strobe |

## Verification
The assertions bound the counters by their limits, and those limits are stable only when configuration changes happen while the block is disabled; the capture logic guarantees that, and the stimulus also changes `pm` and `div16` while enabled to confirm they are held off. The strobe-width property assumes the half period is at least two cycles, which every legal `pm` gives. The stimulus drives `start` as a single-cycle pulse from the falling edge. The pulses land both mid-count and near a strobe, and every pulse is made with `enable` high.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_EDGE = 2'd2
    } baud_state_e;
endpackage

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg #(
    parameter int PM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [PM_W-1:0] pm_in,
    input  logic            d16_in,
    output logic [PM_W-1:0] pm_q,
    output logic            d16_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q  <= '1;
            d16_q <= 1'b1;
        end else if (!enable) begin
            pm_q  <= pm_in;
            d16_q <= d16_in;
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(pm_q) && $stable(d16_q))); // R7
endmodule

// File: rtl/spi_baud_stage.sv
module spi_baud_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = adv && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim); // R2
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int PM_W  = 4,
    parameter int PRE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            start,
    input  logic [PM_W-1:0] pm,
    input  logic            div16,
    output logic            half_tick,
    output logic            sck
);
    import spi_baud_pkg::*;

    localparam int MOD_W = PM_W + 1;

    logic [PM_W-1:0] cfg_pm;
    logic            cfg_d16;
    logic            clr;
    logic            pre_wrap;
    logic            terminal;
    logic [MOD_W-1:0] mod_lim;
    baud_state_e     state_q, state_d;
    logic            sck_q;

    spi_baud_cfg #(.PM_W(PM_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .pm_in(pm), .d16_in(div16),
        .pm_q(cfg_pm), .d16_q(cfg_d16)
    );

    assign clr     = !enable || start;
    assign mod_lim = {cfg_pm, 1'b1};

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_lim;
            assign pre_lim = cfg_d16 ? {PRE_W{1'b1}} : {PRE_W{1'b0}};
            spi_baud_stage #(.W(PRE_W)) u_pre (
                .clk(clk), .rst_n(rst_n), .clr(clr), .adv(1'b1),
                .lim(pre_lim), .wrap(pre_wrap)
            );
        end else begin : g_nopre
            assign pre_wrap = 1'b1;
        end
    endgenerate

    spi_baud_stage #(.W(MOD_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(pre_wrap),
        .lim(mod_lim), .wrap(terminal)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                state_d = enable ? ST_RUN : ST_OFF;
            end
            ST_RUN, ST_EDGE: begin
                if (!enable)       state_d = ST_OFF;
                else if (start)    state_d = ST_RUN;
                else if (terminal) state_d = ST_EDGE;
                else               state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sck_q <= 1'b0;
        else if (clr)               sck_q <= 1'b0;
        else if (state_d == ST_EDGE) sck_q <= ~sck_q;
    end

    assign half_tick = (state_q == ST_EDGE);
    assign sck       = sck_q;

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick); // R4
    AST_SCK_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> half_tick); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!half_tick && !sck)); // R5
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start) |=> (!half_tick && !sck)); // R6
endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start = 1'b0;
    logic [3:0] pm = 4'd0;
    logic       div16 = 1'b0;
    logic       half_tick;
    logic       sck;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    int m_cnt;
    int m_pm;
    bit m_d16;
    bit m_tick;
    bit m_sck;

    spi_baud_gen u_spi_baud_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .pm(pm), .div16(div16), .half_tick(half_tick), .sck(sck)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: one integer count of cycles in the half period
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pm = 15; m_d16 = 1; m_tick = 0; m_sck = 0;
        end else if (!enable) begin
            m_pm = int'(pm); m_d16 = div16; m_cnt = 0; m_tick = 0; m_sck = 0;
        end else if (start) begin
            m_cnt = 0; m_tick = 0; m_sck = 0;
        end else begin
            if (m_cnt == 2 * (m_pm + 1) * (m_d16 ? 16 : 1) - 1) begin
                m_cnt = 0; m_tick = 1; m_sck = !m_sck;
            end else begin
                m_cnt = m_cnt + 1; m_tick = 0;
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'({half_tick, sck}), int'({m_tick, m_sck}), "tick/sck vs model");
        end
    end

    task automatic cycles_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!half_tick && n < 5000);
    endtask

    task automatic gap_check(int exp, string req);
        int n;
        cycles_to_tick(n);
        cycles_to_tick(n);
        check(req, n, exp, "strobe spacing");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state, default slowest configuration
        enable = 1'b1; pm = 4'd0; div16 = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'({half_tick, sck}), 0, "outputs in reset");
        rst_n = 1'b1;
        cycles_to_tick(n);
        check("R1", n, 512, "first strobe with reset configuration");
        check("R4", int'(sck), 1, "sck after first strobe");
        @(negedge clk);
        check("R4", int'(half_tick), 0, "strobe width");
        gap_check(512, "R1");

        // R5: disabled
        cur_req = "R5";
        enable = 1'b0; pm = 4'd3; div16 = 1'b0;
        repeat (4) @(negedge clk);
        check("R5", int'({half_tick, sck}), 0, "outputs while disabled");

        // R8: enable timing, R2 spacing
        cur_req = "R8";
        enable = 1'b1;
        cycles_to_tick(n);
        check("R8", n, 8, "first strobe after enable");
        cur_req = "R2";
        gap_check(8, "R2");
        gap_check(8, "R2");

        enable = 1'b0; pm = 4'd0; @(negedge clk); enable = 1'b1;
        gap_check(2, "R2");
        enable = 1'b0; pm = 4'd15; @(negedge clk); enable = 1'b1;
        gap_check(32, "R2");

        // R3: divide-by-16
        cur_req = "R3";
        enable = 1'b0; pm = 4'd0; div16 = 1'b1; @(negedge clk); enable = 1'b1;
        gap_check(32, "R3");
        enable = 1'b0; pm = 4'd2; @(negedge clk); enable = 1'b1;
        gap_check(96, "R3");

        // R7: changes while enabled are ignored
        cur_req = "R7";
        enable = 1'b0; pm = 4'd1; div16 = 1'b0; @(negedge clk); enable = 1'b1;
        @(negedge clk);
        pm = 4'd9; div16 = 1'b1;
        gap_check(4, "R7");
        gap_check(4, "R7");

        // R6: restart mid-count and right after a strobe
        cur_req = "R6";
        enable = 1'b0; pm = 4'd4; div16 = 1'b0; @(negedge clk); enable = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R6", int'({half_tick, sck}), 0, "outputs after start");
        cycles_to_tick(n);
        check("R6", n, 10, "strobe after mid-count start");
        repeat (9) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R6", int'({half_tick, sck}), 0, "outputs after late start");
        cycles_to_tick(n);
        check("R6", n, 10, "strobe after late start");
        cur_req = "R4";
        gap_check(10, "R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule